// File: doc/BRIEF.md
# Serial Configuration and Result Port for a Four-Input Sampling Converter

This block is the digital front end of a four-input sampling converter. A host talks to it over a four-wire SPI-style slave link: an active-low select, a serial clock that idles high, a data input and a data output. Every frame is sixteen serial clocks long. During a frame the host shifts in a configuration word while the block shifts out the previous conversion result. The result is preceded by the address of the input that produced it.

The analog conversion is not modelled. It appears as a parallel straight-binary sample that is captured when select falls. The block keeps the configuration fields in a register, and each field affects only the following conversion. The register holds the input address, the power mode, the span selector and the output coding. The block drives the input multiplexer, with a pulse marking each switch. It also drives a power-down request and a wake-ready flag. The wake-ready flag is timed in system clocks from a clock-frequency parameter. The serial pins are sampled by the system clock, which must run several times faster than the serial clock.

Top module: `adc_ser_ctrl`

## Requirements
- R1: After reset the register holds input address 0, power mode 11, span bit 0 and coding bit 1. The outputs are mux_ch=0, pwr_down=0, mode_err=0, range_half=0, dout_oe=0 and wake_ready=0.
- R2: Data input is sampled on falling serial edges, most significant first. Edge 1 carries the write-enable bit. Edges 5-6 carry the address, edges 7-8 the power mode, edge 11 the span bit and edge 12 the coding bit. Edges 2, 3, 4, 9 and 10 carry unused bits. With write-enable 1, all fields are committed at edge 12.
- R3: A frame whose write-enable bit is 0 leaves every register field unchanged.
- R4: A frame in which select rises before the 12th falling edge leaves the register unchanged.
- R5: Data input bits after the 12th falling edge have no effect on the register.
- R6: On the 14th falling edge, mux_ch takes the registered address and mux_switch pulses for one system clock. A frame that ends before edge 14 causes no switch.
- R7: Data output carries 16 bits: two zeros, the two address bits of the result's input, then 12 data bits MSB first. The first bit appears after select falls, and each later bit changes after a falling edge. dout_oe is 1 exactly while select is low.
- R8: Coding bit 1 outputs the sample unchanged. Coding bit 0 outputs it with the MSB inverted (two's complement). Each sample uses the coding that was committed before its frame began.
- R9: range_half takes the registered span bit when select falls, with 1 meaning the 0 to REF span.
- R10: With power mode 10, pwr_down rises at the end of the frame and stays high through later frames until a frame commits another mode. Writes are still accepted while shut down.
- R11: With power mode 01, pwr_down rises at each frame end and clears when select next falls.
- R12: wake_ready is 0 while pwr_down is 1. It rises WAKE_NS worth of system clocks after power-up.
- R13: Power mode 00 behaves as mode 11 and holds mode_err at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial configuration data |
| sample_in | input | SAMPLE_W | Converted sample, straight binary |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the data output pad |
| mux_ch | output | 2 | Selected analog input |
| mux_switch | output | 1 | One-cycle pulse when mux_ch is updated |
| range_half | output | 1 | Span of the current conversion, 1 = 0 to REF |
| pwr_down | output | 1 | Power-down request to the analog core |
| wake_ready | output | 1 | Wake-up interval has elapsed |
| mode_err | output | 1 | Invalid power mode is held |

## Verification
The bench sweeps every address, span and coding combination, and drives boundary samples through both codings. An MSB inversion applied to the wrong coding would show as a corrupted first data bit. Frames are cut off at 11 and 13 edges. A design that commits early, or that switches the multiplexer on commit rather than at edge 14, would report the wrong address in the next frame. Unused bits and trailing data-input bits are driven to ones to catch an off-by-one field capture. The power sequences go through full shutdown with a write during shutdown, through auto shutdown and through the invalid mode. A design that woke at select instead of on a mode change, or that raised wake_ready early, would fail those checks.

// File: rtl/adc_ser_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial converter front end.
// Assumes the fixed 12-bit configuration layout; edge numbers count from 1.
package adc_ser_pkg;
    localparam int CH_W        = 2;
    localparam int CFG_EDGES   = 12;
    localparam int E_WRITE     = 1;
    localparam int E_ADDR_HI   = 5;
    localparam int E_ADDR_LO   = 6;
    localparam int E_PWR_HI    = 7;
    localparam int E_PWR_LO    = 8;
    localparam int E_SPAN      = 11;
    localparam int E_CODE      = CFG_EDGES;
    localparam int E_MUX       = 14;

    typedef enum logic [1:0] {
        PWR_BAD  = 2'b00,
        PWR_AUTO = 2'b01,
        PWR_FULL = 2'b10,
        PWR_NORM = 2'b11
    } pwr_mode_e;
endpackage

// File: rtl/adc_ser_edge.sv
`timescale 1ns/1ps
// Detects select and serial-clock edges in the system clock domain and
// numbers the falling edges of a frame. Assumes sclk and cs_n are already
// synchronous and slow relative to clk.
module adc_ser_edge #(
    parameter int FRAME_LEN = 16,
    localparam int EW = $clog2(FRAME_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    output logic          cs_fall,
    output logic          cs_rise,
    output logic          fall_v,
    output logic [EW-1:0] edge_num
);
    logic          cs_q;
    logic          sclk_q;
    logic [EW-1:0] cnt_q;

    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    assign fall_v   = sclk_q & ~sclk & ~cs_n & ~cs_q & (cnt_q < EW'(FRAME_LEN));
    assign edge_num = cnt_q + EW'(1);

    // Track previous pin levels and count falling edges within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_fall)
                cnt_q <= '0;
            else if (fall_v)
                cnt_q <= cnt_q + EW'(1);
        end
    end
endmodule

// File: rtl/adc_ser_cfg.sv
`timescale 1ns/1ps
// Captures configuration fields by edge number, commits them on edge 12 when
// write-enable was set, and switches the input mux on edge 14.
// Assumes edge_num is valid whenever fall_v is high.
module adc_ser_cfg
    import adc_ser_pkg::*;
#(
    parameter int EW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic            cs_fall,
    input  logic            fall_v,
    input  logic [EW-1:0]   edge_num,
    output pwr_mode_e       pwr_q,
    output logic            code_q,
    output logic            span_act,
    output logic [CH_W-1:0] mux_ch,
    output logic            mux_switch
);
    logic            wr_p;
    logic [CH_W-1:0] addr_p;
    logic [1:0]      pwr_p;
    logic            span_p;
    logic [CH_W-1:0] addr_q;
    logic            span_q;

    // Collect fields on their edges, commit on the last field edge, drive the mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p       <= 1'b0;
            addr_p     <= '0;
            pwr_p      <= 2'b11;
            span_p     <= 1'b0;
            addr_q     <= '0;
            pwr_q      <= PWR_NORM;
            span_q     <= 1'b0;
            code_q     <= 1'b1;
            span_act   <= 1'b0;
            mux_ch     <= '0;
            mux_switch <= 1'b0;
        end else begin
            mux_switch <= 1'b0;
            if (cs_fall) begin
                wr_p     <= 1'b0;
                span_act <= span_q;
            end else if (fall_v) begin
                case (edge_num)
                    EW'(E_WRITE):   wr_p      <= din;
                    EW'(E_ADDR_HI): addr_p[1] <= din;
                    EW'(E_ADDR_LO): addr_p[0] <= din;
                    EW'(E_PWR_HI):  pwr_p[1]  <= din;
                    EW'(E_PWR_LO):  pwr_p[0]  <= din;
                    EW'(E_SPAN):    span_p    <= din;
                    EW'(E_CODE): begin
                        if (wr_p) begin
                            addr_q <= addr_p;
                            pwr_q  <= pwr_mode_e'(pwr_p);
                            span_q <= span_p;
                            code_q <= din;
                        end
                    end
                    EW'(E_MUX): begin
                        mux_ch     <= addr_q;
                        mux_switch <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/adc_ser_dout.sv
`timescale 1ns/1ps
// Loads the formatted result word when select falls and shifts it out MSB
// first on each falling serial edge. Assumes the sample is straight binary.
module adc_ser_dout
    import adc_ser_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    localparam int FRAME_LEN = 2 + CH_W + SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_fall,
    input  logic                fall_v,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CH_W-1:0]     ch,
    input  logic                straight,
    output logic                dout
);
    logic [FRAME_LEN-1:0] sh_q;
    logic [SAMPLE_W-1:0]  coded;

    // Two's complement of an offset-binary sample is the MSB inverted.
    always_comb begin
        coded = sample;
        if (!straight)
            coded[SAMPLE_W-1] = ~sample[SAMPLE_W-1];
    end

    // Load the word at frame start, shift it on each counted falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (cs_fall)
            sh_q <= {2'b00, ch, coded};
        else if (fall_v)
            sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
    end

    assign dout = sh_q[FRAME_LEN-1];
endmodule

// File: rtl/adc_ser_pwr.sv
`timescale 1ns/1ps
// Power sequencing: enters shutdown at frame end for the full and auto modes,
// leaves auto shutdown when select falls, and times the wake-up interval.
module adc_ser_pwr
    import adc_ser_pkg::*;
#(
    parameter int WAKE_CYCLES = 250,
    localparam int WW = $clog2(WAKE_CYCLES + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_fall,
    input  logic      cs_rise,
    input  pwr_mode_e pwr,
    output logic      pwr_down,
    output logic      wake_ready
);
    logic [WW-1:0] cnt_q;
    logic          go_down;

    assign go_down = cs_rise && (pwr == PWR_FULL || pwr == PWR_AUTO);

    // Decide the power state at frame boundaries and count the wake-up time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_down   <= 1'b0;
            wake_ready <= 1'b0;
            cnt_q      <= '0;
        end else if (go_down) begin
            pwr_down   <= 1'b1;
            wake_ready <= 1'b0;
            cnt_q      <= '0;
        end else if (pwr_down) begin
            if (cs_rise || (cs_fall && pwr != PWR_FULL))
                pwr_down <= 1'b0;
        end else if (!wake_ready) begin
            if (cnt_q == WW'(WAKE_CYCLES - 1))
                wake_ready <= 1'b1;
            else
                cnt_q <= cnt_q + WW'(1);
        end
    end
endmodule

// File: rtl/adc_ser_ctrl.sv
`timescale 1ns/1ps
// Top of the serial configuration and result port. Assumes the serial pins
// are synchronous to clk and that each serial half period spans at least two
// system clocks.
module adc_ser_ctrl
    import adc_ser_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int CLK_FREQ_HZ = 250_000_000,
    parameter int WAKE_NS     = 1000,
    localparam int FRAME_LEN  = 2 + CH_W + SAMPLE_W,
    localparam int EW         = $clog2(FRAME_LEN + 1),
    localparam int WAKE_RAW   = (CLK_FREQ_HZ / 1_000_000) * WAKE_NS / 1000,
    localparam int WAKE_CYC   = (WAKE_RAW < 1) ? 1 : WAKE_RAW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                dout,
    output logic                dout_oe,
    output logic [CH_W-1:0]     mux_ch,
    output logic                mux_switch,
    output logic                range_half,
    output logic                pwr_down,
    output logic                wake_ready,
    output logic                mode_err
);
    logic          cs_fall;
    logic          cs_rise;
    logic          fall_v;
    logic [EW-1:0] edge_num;
    pwr_mode_e     pwr_cur;
    logic          code_cur;

    adc_ser_edge #(.FRAME_LEN(FRAME_LEN)) u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .fall_v(fall_v), .edge_num(edge_num)
    );

    adc_ser_cfg #(.EW(EW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .din(din), .cs_fall(cs_fall), .fall_v(fall_v),
        .edge_num(edge_num), .pwr_q(pwr_cur), .code_q(code_cur),
        .span_act(range_half), .mux_ch(mux_ch), .mux_switch(mux_switch)
    );

    adc_ser_dout #(.SAMPLE_W(SAMPLE_W)) u_dout (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .fall_v(fall_v),
        .sample(sample_in), .ch(mux_ch), .straight(code_cur), .dout(dout)
    );

    adc_ser_pwr #(.WAKE_CYCLES(WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .pwr(pwr_cur), .pwr_down(pwr_down), .wake_ready(wake_ready)
    );

    assign dout_oe  = ~cs_n;
    assign mode_err = (pwr_cur == PWR_BAD);
endmodule

// File: rtl/adc_ser_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for adc_ser_ctrl, attached by bind below.
module adc_ser_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       dout,
    input logic [1:0] mux_ch,
    input logic       mux_switch,
    input logic       pwr_down,
    input logic       wake_ready,
    input logic       mode_err,
    input logic [1:0] pwr
);
    // R6
    mux_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_ch) |-> mux_switch);
    // R6
    mux_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_switch |=> !mux_switch);
    // R7
    dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$stable(dout))
            |-> (!$past(sclk) && $past(sclk, 2)));
    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == 2'b10 && pwr_down) |=> pwr_down);
    // R12
    ready_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ready |-> !pwr_down);
    // R13
    bad_mode_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && cs_n && $past(cs_n)) |-> !pwr_down);
endmodule

bind adc_ser_ctrl adc_ser_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dout(dout),
    .mux_ch(mux_ch), .mux_switch(mux_switch), .pwr_down(pwr_down),
    .wake_ready(wake_ready), .mode_err(mode_err), .pwr(pwr_cur)
);

// File: tb/adc_ser_ctrl_bench.sv
`timescale 1ns/1ps
module adc_ser_ctrl_bench;
    localparam int WAKE = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [11:0] sample_in = '0;
    logic        dout, dout_oe, mux_switch, range_half, pwr_down, wake_ready, mode_err;
    logic [1:0]  mux_ch;

    int n_tests = 0;
    int n_fail = 0;
    int sw_cnt = 0;
    int sw_at = 0;
    int fall_idx = 0;

    // reference model of committed state
    logic [1:0] m_add = 2'd0, m_mux = 2'd0, m_pm = 2'b11;
    logic       m_rng = 1'b0, m_cod = 1'b1;

    always #2 clk = ~clk;

    adc_ser_ctrl u_adc_ser_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe), .mux_ch(mux_ch),
        .mux_switch(mux_switch), .range_half(range_half), .pwr_down(pwr_down),
        .wake_ready(wake_ready), .mode_err(mode_err)
    );

    always @(negedge clk) if (mux_switch) begin sw_cnt++; sw_at = fall_idx; end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic wr, input logic [1:0] a,
                                       input logic [1:0] p, input logic r, input logic c);
        return {wr, 3'b000, a, p, 2'b00, r, c};
    endfunction

    task automatic frame(input logic [11:0] cfg, input int n_edges,
                         input logic tail, input logic [11:0] smp);
        logic [15:0] rx = '0;
        logic [15:0] exp;
        sample_in = smp;
        exp = {2'b00, m_mux, (m_cod ? smp : {~smp[11], smp[10:0]})};
        sw_cnt = 0;
        fall_idx = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dout_oe === 1'b1, "R7 oe low-select", dout_oe, 1);
        chk(range_half === m_rng, "R9 span", range_half, m_rng);
        chk(pwr_down === (m_pm == 2'b10), "R10/R11 start", pwr_down, (m_pm == 2'b10));
        for (int i = 0; i < n_edges; i++) begin
            rx[15-i] = dout;
            din = (i < 12) ? cfg[11-i] : tail;
            @(negedge clk) sclk = 1'b0;
            fall_idx = i + 1;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (2) @(negedge clk);
        end
        if (n_edges == 16)
            chk(rx === exp, "R7/R8 word", rx, exp);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        if (n_edges >= 12 && cfg[11]) begin
            m_add = cfg[7:6]; m_pm = cfg[5:4]; m_rng = cfg[1]; m_cod = cfg[0];
        end
        if (n_edges >= 14) begin
            m_mux = m_add;
            chk(sw_cnt == 1 && sw_at == 14, "R6 switch edge", sw_at, 14);
        end else begin
            chk(sw_cnt == 0, "R6 no switch", sw_cnt, 0);
        end
        chk(mux_ch === m_mux, "R2/R6 mux", mux_ch, m_mux);
        chk(dout_oe === 1'b0, "R7 oe high-select", dout_oe, 0);
        chk(pwr_down === (m_pm == 2'b10 || m_pm == 2'b01), "R10/R11 end", pwr_down,
            (m_pm == 2'b10 || m_pm == 2'b01));
        chk(mode_err === (m_pm == 2'b00), "R13 err", mode_err, (m_pm == 2'b00));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [11:0] corner [4];
        corner[0] = 12'h000; corner[1] = 12'hFFF; corner[2] = 12'h800; corner[3] = 12'h7FF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mux_ch === 2'd0, "R1 mux", mux_ch, 0);
        chk(pwr_down === 1'b0, "R1 pwr", pwr_down, 0);
        chk(mode_err === 1'b0, "R1 err", mode_err, 0);
        chk(range_half === 1'b0, "R1 span", range_half, 0);
        chk(dout_oe === 1'b0, "R1 oe", dout_oe, 0);
        chk(wake_ready === 1'b0, "R1 ready", wake_ready, 0);
        repeat (WAKE + 20) @(negedge clk);
        chk(wake_ready === 1'b1, "R12 ready after reset", wake_ready, 1);

        // R2 R8 R9 sweep of address, span and coding
        for (int a = 0; a < 4; a++)
            for (int c = 0; c < 2; c++)
                for (int r = 0; r < 2; r++)
                    frame(mk(1'b1, 2'(a), 2'b11, 1'(r), 1'(c)), 16, 1'b0,
                          12'((a * 1237 + c * 311 + r * 97 + 5) & 12'hFFF));
        // R8 boundary samples under both codings
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 4; k++)
                frame(mk(1'b1, 2'(k), 2'b11, 1'b0, 1'(c)), 16, 1'b0, corner[k]);

        // R3 write-enable clear leaves register alone
        frame(mk(1'b0, 2'd2, 2'b10, 1'b1, 1'b0), 16, 1'b0, 12'h123);
        frame(mk(1'b0, 2'd1, 2'b01, 1'b0, 1'b1), 16, 1'b0, 12'h456);
        // R4 early select rise discards the word
        frame(mk(1'b1, 2'd3, 2'b01, 1'b1, 1'b0), 11, 1'b0, 12'h9AB);
        frame(mk(1'b0, 2'd0, 2'b11, 1'b0, 1'b0), 16, 1'b0, 12'h9AB);
        // R6 commit at 12 but frame ends before 14: no switch
        frame(mk(1'b1, 2'd2, 2'b11, 1'b1, 1'b1), 13, 1'b0, 12'h321);
        frame(mk(1'b0, 2'd0, 2'b11, 1'b0, 1'b0), 16, 1'b0, 12'hC3C);
        // R5 trailing ones and unused bits set have no effect
        frame(mk(1'b1, 2'd1, 2'b11, 1'b0, 1'b1) | 12'h70C, 16, 1'b1, 12'h5A5);
        frame(mk(1'b0, 2'd3, 2'b00, 1'b1, 1'b0), 16, 1'b1, 12'hA5A);

        // R13 invalid mode acts as normal
        frame(mk(1'b1, 2'd2, 2'b00, 1'b0, 1'b1), 16, 1'b0, 12'h0F0);
        repeat (WAKE + 20) @(negedge clk);
        chk(wake_ready === 1'b1, "R13 stays up", wake_ready, 1);

        // R11 auto shutdown
        frame(mk(1'b1, 2'd1, 2'b01, 1'b0, 1'b1), 16, 1'b0, 12'h111);
        chk(wake_ready === 1'b0, "R12 ready low in shutdown", wake_ready, 0);
        frame(mk(1'b1, 2'd3, 2'b01, 1'b0, 1'b0), 16, 1'b0, 12'h222);
        chk(wake_ready === 1'b0, "R12 ready low after auto frame", wake_ready, 0);

        // R10 full shutdown, write accepted while down
        frame(mk(1'b1, 2'd2, 2'b10, 1'b1, 1'b1), 16, 1'b0, 12'h333);
        repeat (WAKE + 20) @(negedge clk);
        chk(pwr_down === 1'b1 && wake_ready === 1'b0, "R10 stays down", pwr_down, 1);
        frame(mk(1'b1, 2'd0, 2'b10, 1'b0, 1'b1), 16, 1'b0, 12'h444);
        frame(mk(1'b1, 2'd1, 2'b11, 1'b0, 1'b1), 16, 1'b0, 12'h555);
        chk(wake_ready === 1'b0, "R12 ready not yet", wake_ready, 0);
        repeat (WAKE + 20) @(negedge clk);
        chk(wake_ready === 1'b1, "R12 ready after wake", wake_ready, 1);
        frame(mk(1'b0, 2'd0, 2'b11, 1'b0, 1'b0), 16, 1'b0, 12'h666);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule